// File: doc/BRIEF.md
# Multicycle Accumulator Processor with Stack-Based Interrupts

This block is a small processor core with its own control sequencer, registers and a 2048-word internal memory. Every instruction runs as a series of subcycles: fetch, an optional indirect subcycle that looks up an operand address, execute, and an interrupt subcycle when a request is pending and enabled. All memory traffic passes through a memory address register and a memory buffer register. The core has an accumulator, an 11-bit pointer register, a downward-growing stack, a zero flag and an interrupt-enable flag.

A program is placed in memory through a load port while reset is held. After reset is released, the core runs on its own. A one-cycle retire pulse and a set of debug outputs expose the architectural state after each instruction, so an external reference model can follow the core step by step. An acknowledge pulse tells the interrupt source when the core has entered its handler.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, `dbg_pc`, `dbg_ac`, `dbg_bx` and `dbg_sp` read zero, `dbg_zf` is 0, `dbg_ie` is 1, and `retire` and `irq_ack` are low.
- R2: A load-port write (`ld_we`) changes memory only while `rst` is high. A load-port write made while the core runs has no effect on memory.
- R3: An instruction word is opcode [15:12], indirect bit [11] and address or displacement [10:0]. The sequence is fetch, then indirect (only when bit 11 is set on opcodes 1, 2 or 8), then execute, then interrupt when one is taken. The PC advances by one during fetch. Opcodes 0 and 9 to 15 only advance the PC.
- R4: Opcode 1 (add) sets AC to AC + mem[EA]. EA is the address field, or the low 11 bits of mem[field] when the indirect bit is set.
- R5: Opcode 2 (move) sets AC to mem[EA]. With the indirect bit set, this gives AC = mem[mem[X]].
- R6: Opcode 3 sets AC to AC + mem[BX] with no indirect subcycle. Opcode 8 sets BX to the low 11 bits of mem[EA].
- R7: Opcode 4 (jump on zero): when the zero flag is set, PC becomes (address of the next instruction + displacement) modulo 2048. When the flag is clear, the PC is unchanged.
- R8: The zero flag takes the value (AC == 0) on every accumulator write. Otherwise it changes only on a return from interrupt.
- R9: Opcode 5 (call) decrements SP, stores the return address at the new SP, and loads PC with X. Opcode 6 (return) loads PC from mem[SP] and then increments SP. SP resets to 0, so the first push lands at address 2047.
- R10: When `irq` is high and the enable flag is set as execute finishes, the core pushes PC, then pushes the flag word {14'b0, ie, zf}, loads PC with the handler vector (1024 by default), clears the enable flag and pulses `irq_ack` for exactly one cycle.
- R11: Opcode 7 (return from interrupt) pops the flag word and restores zf and ie from bits 0 and 1. It then pops the PC.
- R12: `retire` pulses for one cycle after each instruction completes. In that cycle the debug outputs show the state after the instruction. `retire` and `irq_ack` never pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request level |
| irq_ack | output | 1 | One-cycle pulse on handler entry |
| ld_we | input | 1 | Program load write enable (honoured in reset) |
| ld_addr | input | 11 | Program load address |
| ld_data | input | 16 | Program load data |
| retire | output | 1 | One-cycle pulse per completed instruction |
| dbg_pc | output | 11 | Program counter |
| dbg_ac | output | 16 | Accumulator |
| dbg_bx | output | 11 | Pointer register |
| dbg_sp | output | 11 | Stack pointer |
| dbg_zf | output | 1 | Zero flag |
| dbg_ie | output | 1 | Interrupt enable flag |

## Verification
The assertions check the following on every cycle:
- The subcycle ordering: indirect only follows fetch, and interrupt only follows execute.
- SP moves by at most one per cycle.
- The acknowledge and retire pulses are single-cycle and never overlap.
- The enable flag is clear whenever the acknowledge pulse is high.
- The accumulator stays still during fetch.

Only the bench scenarios can show the rest:
- That each opcode produces the right values, including the double lookup of a move through a pointer and the relative jump target.
- That stack contents are popped in reverse order.
- That a load-port write made while running is ignored.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPW = 4;

  typedef enum logic [1:0] {PH_FETCH, PH_INDIR, PH_EXEC, PH_INTR} phase_e;

  localparam logic [OPW-1:0] OP_NOP   = 4'h0;
  localparam logic [OPW-1:0] OP_ADD   = 4'h1;
  localparam logic [OPW-1:0] OP_MOV   = 4'h2;
  localparam logic [OPW-1:0] OP_ADDBX = 4'h3;
  localparam logic [OPW-1:0] OP_JZ    = 4'h4;
  localparam logic [OPW-1:0] OP_CALL  = 4'h5;
  localparam logic [OPW-1:0] OP_RET   = 4'h6;
  localparam logic [OPW-1:0] OP_IRET  = 4'h7;
  localparam logic [OPW-1:0] OP_LBX   = 4'h8;
endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (load_en)    arr[load_addr] <= load_data;
    else if (wr_en) arr[addr]      <= wr_data;
  end

  assign rd_data = arr[addr];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          add_en,
  output logic [DW-1:0] y,
  output logic          zero
);
  always_comb begin
    y    = add_en ? (a + b) : b;
    zero = (y == '0);
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int AW   = 11,
  parameter int IVEC = 1024,
  parameter int DW   = OPW + 1 + AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  output logic          irq_ack,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic          retire,
  output logic [AW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_ac,
  output logic [AW-1:0] dbg_bx,
  output logic [AW-1:0] dbg_sp,
  output logic          dbg_zf,
  output logic          dbg_ie
);
  localparam int STW = 3;

  function automatic logic [AW-1:0] rel_target(input logic [AW-1:0] nxt, input logic [AW-1:0] disp);
    return nxt + disp;
  endfunction

  function automatic logic need_ind(input logic [DW-1:0] w);
    logic [OPW-1:0] o;
    o = w[DW-1 -: OPW];
    return w[AW] && (o == OP_ADD || o == OP_MOV || o == OP_LBX);
  endfunction

  function automatic logic [DW-1:0] flag_word(input logic ie, input logic zf);
    return {{(DW-2){1'b0}}, ie, zf};
  endfunction

  phase_e         phase_q;
  logic [STW-1:0] step_q;
  logic [AW-1:0]  pc_q, bx_q, sp_q, mar_q;
  logic [DW-1:0]  ac_q, ir_q, mbr_q;
  logic           zf_q, ie_q, retire_q, ack_q;

  logic [OPW-1:0] ir_op;
  logic [AW-1:0]  ir_ea;
  logic [DW-1:0]  mem_rd, alu_y;
  logic           alu_zero, exec_done, take_irq, mem_we;

  assign ir_op = ir_q[DW-1 -: OPW];
  assign ir_ea = ir_q[AW-1:0];

  always_comb begin
    unique case (ir_op)
      OP_ADD, OP_MOV, OP_ADDBX, OP_LBX, OP_RET: exec_done = (phase_q == PH_EXEC) && (step_q == 3'd2);
      OP_CALL:                                  exec_done = (phase_q == PH_EXEC) && (step_q == 3'd1);
      OP_IRET:                                  exec_done = (phase_q == PH_EXEC) && (step_q == 3'd4);
      default:                                  exec_done = (phase_q == PH_EXEC) && (step_q == 3'd0);
    endcase
  end

  assign take_irq = exec_done && irq && ie_q;
  assign mem_we   = ((phase_q == PH_EXEC) && (ir_op == OP_CALL) && (step_q == 3'd1)) ||
                    ((phase_q == PH_INTR) && (step_q == 3'd1 || step_q == 3'd3));

  acc_cpu_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .load_en(rst && ld_we), .load_addr(ld_addr), .load_data(ld_data),
    .wr_en(mem_we && !rst), .addr(mar_q), .wr_data(mbr_q), .rd_data(mem_rd)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .a(ac_q), .b(mbr_q), .add_en(ir_op != OP_MOV), .y(alu_y), .zero(alu_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_FETCH;
      step_q   <= '0;
      pc_q     <= '0;
      bx_q     <= '0;
      sp_q     <= '0;
      mar_q    <= '0;
      ac_q     <= '0;
      ir_q     <= '0;
      mbr_q    <= '0;
      zf_q     <= 1'b0;
      ie_q     <= 1'b1;
      retire_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      retire_q <= 1'b0;
      ack_q    <= 1'b0;
      unique case (phase_q)
        PH_FETCH: begin
          unique case (step_q)
            3'd0: begin mar_q <= pc_q; step_q <= 3'd1; end
            3'd1: begin mbr_q <= mem_rd; pc_q <= pc_q + 1'b1; step_q <= 3'd2; end
            default: begin
              ir_q    <= mbr_q;
              step_q  <= '0;
              phase_q <= need_ind(mbr_q) ? PH_INDIR : PH_EXEC;
            end
          endcase
        end
        PH_INDIR: begin
          unique case (step_q)
            3'd0: begin mar_q <= ir_ea; step_q <= 3'd1; end
            3'd1: begin mbr_q <= mem_rd; step_q <= 3'd2; end
            default: begin
              ir_q[AW-1:0] <= mbr_q[AW-1:0];
              step_q       <= '0;
              phase_q      <= PH_EXEC;
            end
          endcase
        end
        PH_EXEC: begin
          if (exec_done) begin
            step_q   <= '0;
            phase_q  <= take_irq ? PH_INTR : PH_FETCH;
            retire_q <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
          unique case (ir_op)
            OP_ADD, OP_MOV, OP_ADDBX, OP_LBX: begin
              if (step_q == 3'd0)      mar_q <= (ir_op == OP_ADDBX) ? bx_q : ir_ea;
              else if (step_q == 3'd1) mbr_q <= mem_rd;
              else if (ir_op == OP_LBX) bx_q <= mbr_q[AW-1:0];
              else begin ac_q <= alu_y; zf_q <= alu_zero; end
            end
            OP_JZ: if (zf_q) pc_q <= rel_target(pc_q, ir_ea);
            OP_CALL: begin
              if (step_q == 3'd0) begin
                mbr_q <= {{(DW-AW){1'b0}}, pc_q};
                mar_q <= sp_q - 1'b1;
                sp_q  <= sp_q - 1'b1;
              end else begin
                pc_q <= ir_ea;
              end
            end
            OP_RET, OP_IRET: begin
              unique case (step_q)
                3'd0: mar_q <= sp_q;
                3'd1: begin mbr_q <= mem_rd; sp_q <= sp_q + 1'b1; end
                3'd2: begin
                  if (ir_op == OP_RET) pc_q <= mbr_q[AW-1:0];
                  else begin zf_q <= mbr_q[0]; ie_q <= mbr_q[1]; mar_q <= sp_q; end
                end
                3'd3: begin mbr_q <= mem_rd; sp_q <= sp_q + 1'b1; end
                default: pc_q <= mbr_q[AW-1:0];
              endcase
            end
            default: ;
          endcase
        end
        PH_INTR: begin
          step_q <= step_q + 1'b1;
          unique case (step_q)
            3'd0: begin
              mbr_q <= {{(DW-AW){1'b0}}, pc_q};
              mar_q <= sp_q - 1'b1;
              sp_q  <= sp_q - 1'b1;
            end
            3'd1: ;
            3'd2: begin
              mbr_q <= flag_word(ie_q, zf_q);
              mar_q <= sp_q - 1'b1;
              sp_q  <= sp_q - 1'b1;
            end
            default: begin
              pc_q    <= AW'(IVEC);
              ie_q    <= 1'b0;
              ack_q   <= 1'b1;
              step_q  <= '0;
              phase_q <= PH_FETCH;
            end
          endcase
        end
        default: phase_q <= PH_FETCH;
      endcase
    end
  end

  assign irq_ack = ack_q;
  assign retire  = retire_q;
  assign dbg_pc  = pc_q;
  assign dbg_ac  = ac_q;
  assign dbg_bx  = bx_q;
  assign dbg_sp  = sp_q;
  assign dbg_zf  = zf_q;
  assign dbg_ie  = ie_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input phase_e        phase,
  input logic          irq_ack,
  input logic          retire,
  input logic          dbg_ie,
  input logic [AW-1:0] dbg_sp,
  input logic [DW-1:0] dbg_ac
);
  AST_INDIR_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INDIR) |-> ($past(phase) == PH_FETCH || $past(phase) == PH_INDIR)); // R3
  AST_INTR_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INTR && $past(phase) != PH_INTR) |-> ($past(phase) == PH_EXEC)); // R10
  AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(dbg_sp) |-> (dbg_sp == AW'($past(dbg_sp) - 1'b1) || dbg_sp == AW'($past(dbg_sp) + 1'b1))); // R9
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack); // R10
  AST_ACK_IE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !dbg_ie); // R10
  AST_RETIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    retire |=> !retire); // R12
  AST_RETIRE_ACK_APART: assert property (@(posedge clk) disable iff (rst)
    !(retire && irq_ack)); // R12
  AST_FETCH_KEEPS_AC: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && $past(phase) == PH_FETCH) |-> $stable(dbg_ac)); // R8
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .phase(phase_q), .irq_ack(irq_ack), .retire(retire),
  .dbg_ie(dbg_ie), .dbg_sp(dbg_sp), .dbg_ac(dbg_ac)
);

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 11;
  localparam int DW    = 16;
  localparam int IVEC  = 1024;
  localparam int DEPTH = 2048;

  logic clk = 1'b0, rst = 1'b1, irq = 1'b0, ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic irq_ack, retire, dbg_zf, dbg_ie;
  logic [AW-1:0] dbg_pc, dbg_bx, dbg_sp;
  logic [DW-1:0] dbg_ac;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu #(.AW(AW), .IVEC(IVEC)) dut_i (
    .clk(clk), .rst(rst), .irq(irq), .irq_ack(irq_ack), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .retire(retire), .dbg_pc(dbg_pc), .dbg_ac(dbg_ac), .dbg_bx(dbg_bx),
    .dbg_sp(dbg_sp), .dbg_zf(dbg_zf), .dbg_ie(dbg_ie)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, idle = 0;
  bit running = 0, irq_on = 0;
  logic [DW-1:0] mm [DEPTH];
  logic [AW-1:0] m_pc, m_bx, m_sp;
  logic [DW-1:0] m_ac;
  logic m_zf, m_ie;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [AW-1:0] eff_addr(input logic [DW-1:0] w);
    logic [3:0] op;
    op = w[15:12];
    if (w[11] && (op == 4'h1 || op == 4'h2 || op == 4'h8)) return mm[w[10:0]][10:0];
    return w[10:0];
  endfunction

  task automatic model_reset();
    m_pc = '0; m_bx = '0; m_sp = '0; m_ac = '0; m_zf = 1'b0; m_ie = 1'b1;
  endtask

  task automatic model_step(output string tag);
    logic [DW-1:0] w, fw;
    logic [AW-1:0] ea;
    w  = mm[m_pc];
    m_pc = m_pc + 1'b1;
    ea = eff_addr(w);
    case (w[15:12])
      4'h1: begin m_ac = m_ac + mm[ea]; m_zf = (m_ac == 0); tag = "R4"; end
      4'h2: begin m_ac = mm[ea]; m_zf = (m_ac == 0); tag = "R5"; end
      4'h3: begin m_ac = m_ac + mm[m_bx]; m_zf = (m_ac == 0); tag = "R6"; end
      4'h8: begin m_bx = mm[ea][10:0]; tag = "R6"; end
      4'h4: begin if (m_zf) m_pc = m_pc + w[10:0]; tag = "R7"; end
      4'h5: begin m_sp = m_sp - 1'b1; mm[m_sp] = {5'b0, m_pc}; m_pc = w[10:0]; tag = "R9"; end
      4'h6: begin m_pc = mm[m_sp][10:0]; m_sp = m_sp + 1'b1; tag = "R9"; end
      4'h7: begin
        fw = mm[m_sp]; m_sp = m_sp + 1'b1; m_zf = fw[0]; m_ie = fw[1];
        m_pc = mm[m_sp][10:0]; m_sp = m_sp + 1'b1; tag = "R11";
      end
      default: tag = "R3";
    endcase
  endtask

  task automatic model_irq();
    chk(m_ie == 1'b1, "R10", "enable flag at entry", 0, 1);
    m_sp = m_sp - 1'b1; mm[m_sp] = {5'b0, m_pc};
    m_sp = m_sp - 1'b1; mm[m_sp] = {14'b0, m_ie, m_zf};
    m_pc = AW'(IVEC); m_ie = 1'b0;
  endtask

  task automatic compare(input string tag);
    chk(dbg_pc == m_pc, tag, "pc", dbg_pc, m_pc);
    chk(dbg_ac == m_ac, tag, "ac", dbg_ac, m_ac);
    chk(dbg_bx == m_bx, tag, "bx", dbg_bx, m_bx);
    chk(dbg_sp == m_sp, tag, "sp", dbg_sp, m_sp);
    chk(dbg_ie == m_ie, tag, "ie", dbg_ie, m_ie);
    chk(dbg_zf == m_zf, {tag, " R8"}, "zf", dbg_zf, m_zf);
  endtask

  // Reference comparison at each retire (R12) and handler entry (R10)
  always @(negedge clk) begin
    string t;
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: run exceeded cycle limit actual=%0d expected<190000", cyc);
      finish_run();
    end
    if (running) begin
      if (retire) begin
        model_step(t);
        compare({t, " R12"});
        idle = 0;
      end else begin
        idle++;
      end
      if (irq_ack) begin
        model_irq();
        compare("R10");
      end
      if (idle > 300) begin
        n_bad++;
        $display("FAIL watchdog: no retire R12 actual=%0d expected<=300", idle);
        finish_run();
      end
    end
  end

  always @(negedge clk) begin
    if (irq_on) begin
      if (irq_ack) irq = 1'b0;
      else if (!irq && ($urandom % 40) == 0) irq = 1'b1;
    end else begin
      irq = 1'b0;
    end
  end

  task automatic put(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = AW'(a); ld_data = d;
    mm[a] = d;
  endtask

  function automatic logic [DW-1:0] rnd_data();
    logic [31:0] r;
    r = $urandom;
    if (r[31:30] == 2'b00) return '0;
    return {r[15:11], 1'b0, r[9:0]};
  endfunction

  task automatic load_common();
    for (int i = 0; i < 48; i++) put(16'h200 + i, rnd_data());
    put(16'h250, 16'h0251);
    put(16'h251, 16'h0000);
    put(16'h300, 16'h1201);     // subroutine: add
    put(16'h301, 16'h6000);     // return
    put(IVEC,     16'h1202);    // handler: add
    put(IVEC + 1, 16'h7000);    // return from interrupt
  endtask

  task automatic load_tail(input int at);
    for (int i = 0; i < 4; i++) put(at + i, 16'h0000);
    put(at + 4, 16'h2A50);      // move through pointer -> zero
    put(at + 5, 16'h47FF);      // jump-on-zero to itself
  endtask

  task automatic run_prog(input int cycles, input bit directed);
    @(negedge clk);
    ld_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    chk(dbg_pc == 0 && dbg_ac == 0 && dbg_bx == 0 && dbg_sp == 0, "R1", "regs in reset",
        dbg_pc | dbg_ac | dbg_bx | dbg_sp, 0);
    chk(dbg_zf == 1'b0 && dbg_ie == 1'b1, "R1", "flags in reset", {dbg_ie, dbg_zf}, 2'b10);
    chk(!retire && !irq_ack, "R1", "pulses in reset", {retire, irq_ack}, 0);
    rst = 1'b0;
    running = 1'b1;
    irq_on = 1'b1;
    if (directed) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 11'h210; ld_data = 16'hBEEF;   // must be ignored (R2)
      @(negedge clk);
      ld_we = 1'b0;
      while (!retire) @(negedge clk);
      chk(dbg_ac == 16'h0005, "R2", "run-time load ignored", dbg_ac, 16'h0005);
      cycles = cycles - 10;
    end
    repeat (cycles) @(negedge clk);
    rst = 1'b1;
    running = 1'b0;
    irq_on = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) put(i, 16'h0000);

    // Directed program covering every opcode class
    load_common();
    put(16'h210, 16'h0005);
    put(16'h211, 16'h0212);
    put(16'h212, 16'h0003);
    put(16'h213, 16'h0214);
    put(16'h214, 16'hFFF8);
    put(0, 16'h2210);   // move       -> 5          R5
    put(1, 16'h1A11);   // add ind    -> 8          R4
    put(2, 16'h8213);   // load BX    -> 0x214      R6
    put(3, 16'h3000);   // add [BX]   -> 0, zf=1    R6 R8
    put(4, 16'h4001);   // jz +1 skips word 5       R7
    put(5, 16'h1212);
    put(6, 16'h5300);   // call, subroutine returns R9
    put(7, 16'h9000);   // unused opcode            R3
    load_tail(8);
    run_prog(600, 1'b1);

    // Constrained random programs
    for (int p = 0; p < 12; p++) begin
      int plen;
      plen = 20 + ($urandom % 12);
      load_common();
      for (int i = 0; i < plen; i++) begin
        logic [DW-1:0] w;
        logic [AW-1:0] da;
        int r;
        r  = $urandom % 10;
        da = AW'(16'h200 + ($urandom % 48));
        case (r)
          0, 1, 9: w = {4'h1, 1'($urandom), da};
          2:       w = {4'h2, 1'($urandom), da};
          3:       w = 16'h3000;
          4:       w = {4'h8, 1'($urandom), da};
          5, 6:    w = {4'h4, 1'b0, AW'(1 + ($urandom % 3))};
          7:       w = 16'h5300;
          default: w = {4'(9 + ($urandom % 7)), 12'($urandom)};
        endcase
        put(i, w);
      end
      load_tail(plen);
      run_prog(700, 1'b0);
    end
    finish_run();
  end
endmodule